// File: doc/BRIEF.md
# Level-Priority Vectored Interrupt Controller

The controller gathers thirteen interrupt request lines, numbered 1 to 13, and picks one winning source for the CPU. Each source owns an 8-bit control register that packs an autovector flag, a 3-bit interrupt level and a 2-bit sub-priority. Arbitration compares the combined 5-bit level and sub-priority field across all sources that are both requesting and unmasked.

The result goes to the CPU as a 3-bit level and an 8-bit vector number, both registered. The vector is either a fixed base plus the level, or the contents of a dedicated vector register for the three sources that have one, or a fixed fallback code. Software reaches the control, mask, pending and vector registers through a simple single-cycle register port. The read path is combinational, and a write takes effect at the clock edge.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, the control registers of sources 1 to 13 hold 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00 and 0x00. The mask register holds 0x3FFE, the software vector register holds 0x0F, and both serial-port vector registers hold 0x00.
- R2: A source is active only while its request input (irq_i bit n for source n) is 1 and its mask bit n is 0. While no source is active, level_o and vector_o are 0.
- R3: The winning source is the active source with the largest value in control bits 4:0. On equal values, the lowest-numbered source wins.
- R4: If the winning control bits 4:0 are below 4, the controller presents no interrupt: level_o is 0 and vector_o is 0.
- R5: level_o equals the winner's control bits 4:2. When the winner's control bit 7 is 1, vector_o equals 24 plus that level.
- R6: When the winner's control bit 7 is 0, vector_o depends on the winning source. Source 8 uses the software vector register, source 12 uses serial-port vector register A, and source 13 uses serial-port vector register B. Every other source gets 0x0F.
- R7: Reading the pending register returns the current irq_i value for bits 1 to 13, with no storage in between.
- R8: level_o and vector_o are registered. They show the result for the inputs and registers present before a clock edge, starting at that edge.
- R9: Bit 0 and bits 15:14 of the mask and pending registers read as 0 and cannot be written. irq_i bits 0, 14 and 15 never cause an interrupt.
- R10: The register map is as follows. Address n (1 to 13) is the control register of source n (data bits 7:0). Address 0x10 is the mask register. Address 0x11 is the pending register, which is read-only. Address 0x12 is the software vector register, 0x13 is serial-port vector register A and 0x14 is serial-port vector register B. All other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines, bit n is source n |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| level_o | output | 3 | Interrupt level for the CPU, 0 means none |
| vector_o | output | 8 | Vector number for the CPU |

## Verification
The bench builds the controller with its default of thirteen sources. This puts all three dedicated vector sources (8, 12 and 13) and the ignored request bits 0, 14 and 15 within reach of directed tests. Directed phases cover several cases: the tie between sources 7 and 8 that reset leaves in place, autovectored and dedicated-vector winners, a winner suppressed because its level field is zero, and the masking of the unused bits. A phase of random requests and random register writes then runs against the reference model, which is compared with the outputs on every clock.

// File: rtl/prio_vec_intc_pkg.sv
package prio_vec_intc_pkg;

  localparam int NUM_SRC = 13;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 5;
  localparam int CTRL_W  = 8;
  localparam int VEC_W   = 8;
  localparam int LVL_W   = 3;
  localparam int KEY_W   = 5;

  localparam int SW_SRC  = 8;
  localparam int VA_SRC  = 12;
  localparam int VB_SRC  = 13;

  localparam logic [VEC_W-1:0] AUTO_BASE    = 8'd24;
  localparam logic [VEC_W-1:0] FALLBACK_VEC = 8'h0F;
  localparam logic [VEC_W-1:0] SW_VEC_RST   = 8'h0F;
  localparam logic [VEC_W-1:0] UART_VEC_RST = 8'h00;
  localparam logic [KEY_W-1:0] MIN_KEY      = 5'd4;

  localparam logic [ADDR_W-1:0] A_MASK = 5'h10;
  localparam logic [ADDR_W-1:0] A_PEND = 5'h11;
  localparam logic [ADDR_W-1:0] A_SWV  = 5'h12;
  localparam logic [ADDR_W-1:0] A_VA   = 5'h13;
  localparam logic [ADDR_W-1:0] A_VB   = 5'h14;

  // bits 1..n set
  function automatic logic [REG_W-1:0] used_bits(int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 1; i <= n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_rst(int n);
    if (n <= 7)       return CTRL_W'(n * 4);
    else if (n == 8)  return 8'h1C;
    else if (n <= 11) return 8'h80;
    else              return 8'h00;
  endfunction

endpackage

// File: rtl/prio_vec_intc_regs.sv
module prio_vec_intc_regs
  import prio_vec_intc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  input  logic [REG_W-1:0]              pend_i,
  output logic [REG_W-1:0]              rdata_o,
  output logic [N_SRC:0][CTRL_W-1:0]    ctrl_o,
  output logic [REG_W-1:0]              mask_o,
  output logic [VEC_W-1:0]              swv_o,
  output logic [VEC_W-1:0]              vav_o,
  output logic [VEC_W-1:0]              vbv_o
);

  localparam logic [REG_W-1:0] Used = used_bits(N_SRC);

  assign ctrl_o[0] = '0;

  for (genvar g = 1; g <= N_SRC; g++) begin : g_ctrl
    logic [CTRL_W-1:0] ctrl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 ctrl_q <= ctrl_rst(g);
      else if (we_i && addr_i == ADDR_W'(g))       ctrl_q <= wdata_i[CTRL_W-1:0];
    end
    assign ctrl_o[g] = ctrl_q;
  end

  logic [REG_W-1:0] mask_q;
  logic [VEC_W-1:0] swv_q, vav_q, vbv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= Used;
      swv_q  <= SW_VEC_RST;
      vav_q  <= UART_VEC_RST;
      vbv_q  <= UART_VEC_RST;
    end else if (we_i) begin
      case (addr_i)
        A_MASK:  mask_q <= wdata_i & Used;
        A_SWV:   swv_q  <= wdata_i[VEC_W-1:0];
        A_VA:    vav_q  <= wdata_i[VEC_W-1:0];
        A_VB:    vbv_q  <= wdata_i[VEC_W-1:0];
        default: ;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign swv_o  = swv_q;
  assign vav_o  = vav_q;
  assign vbv_o  = vbv_q;

  always_comb begin
    rdata_o = '0;
    for (int s = 1; s <= N_SRC; s++)
      if (addr_i == ADDR_W'(s)) rdata_o = REG_W'(ctrl_o[s]);
    case (addr_i)
      A_MASK:  rdata_o = mask_q;
      A_PEND:  rdata_o = pend_i & Used;
      A_SWV:   rdata_o = REG_W'(swv_q);
      A_VA:    rdata_o = REG_W'(vav_q);
      A_VB:    rdata_o = REG_W'(vbv_q);
      default: ;
    endcase
  end

endmodule

// File: rtl/prio_vec_intc_arb.sv
module prio_vec_intc_arb
  import prio_vec_intc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:0][CTRL_W-1:0] ctrl_i,
  input  logic [REG_W-1:0]           pend_i,
  input  logic [REG_W-1:0]           mask_i,
  output logic [REG_W-1:0]           active_o,
  output logic [IDX_W-1:0]           win_o,
  output logic                       hit_o
);

  localparam logic [REG_W-1:0] Used = used_bits(N_SRC);

  logic [KEY_W-1:0] best;

  assign active_o = pend_i & ~mask_i & Used;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best  = '0;
    win_o = '0;
    for (int s = 1; s <= N_SRC; s++) begin
      if (active_o[s] && ctrl_i[s][KEY_W-1:0] > best) begin
        best  = ctrl_i[s][KEY_W-1:0];
        win_o = IDX_W'(s);
      end
    end
  end

  assign hit_o = (best >= MIN_KEY);

endmodule

// File: rtl/prio_vec_intc_vec.sv
module prio_vec_intc_vec
  import prio_vec_intc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:0][CTRL_W-1:0] ctrl_i,
  input  logic [IDX_W-1:0]           win_i,
  input  logic                       hit_i,
  input  logic [VEC_W-1:0]           swv_i,
  input  logic [VEC_W-1:0]           vav_i,
  input  logic [VEC_W-1:0]           vbv_i,
  output logic [LVL_W-1:0]           level_o,
  output logic [VEC_W-1:0]           vector_o
);

  logic [CTRL_W-1:0] wctrl;
  logic [VEC_W-1:0]  own_vec;

  always_comb begin
    wctrl = '0;
    for (int s = 1; s <= N_SRC; s++)
      if (win_i == IDX_W'(s)) wctrl = ctrl_i[s];
  end

  always_comb begin
    if      (win_i == IDX_W'(SW_SRC)) own_vec = swv_i;
    else if (win_i == IDX_W'(VA_SRC)) own_vec = vav_i;
    else if (win_i == IDX_W'(VB_SRC)) own_vec = vbv_i;
    else                              own_vec = FALLBACK_VEC;
  end

  always_comb begin
    if (!hit_i) begin
      level_o  = '0;
      vector_o = '0;
    end else begin
      level_o  = wctrl[4:2];
      vector_o = wctrl[7] ? (AUTO_BASE + VEC_W'(wctrl[4:2])) : own_vec;
    end
  end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import prio_vec_intc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  irq_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [VEC_W-1:0]  vector_o
);

  localparam int IDX_W = $clog2(N_SRC + 1);

  logic [N_SRC:0][CTRL_W-1:0] ctrl_w;
  logic [REG_W-1:0]           mask_w, active_w;
  logic [VEC_W-1:0]           swv_w, vav_w, vbv_w, vec_d;
  logic [IDX_W-1:0]           win_w;
  logic                       hit_w;
  logic [LVL_W-1:0]           lvl_d, level_q;
  logic [VEC_W-1:0]           vector_q;

  prio_vec_intc_regs #(.N_SRC(N_SRC)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (irq_i),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl_w),
    .mask_o  (mask_w),
    .swv_o   (swv_w),
    .vav_o   (vav_w),
    .vbv_o   (vbv_w)
  );

  prio_vec_intc_arb #(.N_SRC(N_SRC)) i_arb (
    .ctrl_i   (ctrl_w),
    .pend_i   (irq_i),
    .mask_i   (mask_w),
    .active_o (active_w),
    .win_o    (win_w),
    .hit_o    (hit_w)
  );

  prio_vec_intc_vec #(.N_SRC(N_SRC)) i_vec (
    .ctrl_i   (ctrl_w),
    .win_i    (win_w),
    .hit_i    (hit_w),
    .swv_i    (swv_w),
    .vav_i    (vav_w),
    .vbv_i    (vbv_w),
    .level_o  (lvl_d),
    .vector_o (vec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= '0;
      vector_q <= '0;
    end else begin
      level_q  <= lvl_d;
      vector_q <= vec_d;
    end
  end

  assign level_o  = level_q;
  assign vector_o = vector_q;

endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk
  import prio_vec_intc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_W-1:0]  irq_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [LVL_W-1:0]  level_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic [REG_W-1:0]  active_i
);

  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i == '0) |=> (level_o == '0 && vector_o == '0));

  assert_suppress_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> (vector_o == '0));

  assert_level_has_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != '0) |-> ($past(active_i) != '0));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && $stable(irq_i)) |=> ($stable(level_o) && $stable(vector_o)));

  assert_mask_unused_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_MASK) |-> (rdata_o[0] == 1'b0 && rdata_o[REG_W-1:REG_W-2] == 2'b00));

  assert_pend_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_PEND) |-> (rdata_o == (irq_i & used_bits(NUM_SRC))));

endmodule

bind prio_vec_intc prio_vec_intc_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .level_o  (level_o),
  .vector_o (vector_o),
  .active_i (active_w)
);

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  level;
  logic [7:0]  vector;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference state
  int m_ctrl[14];
  int m_mask, m_sw, m_va, m_vb;
  int exp_lvl = 0, exp_vec = 0;

  always #5 clk = ~clk;

  prio_vec_intc i_prio_vec_intc (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .level_o(level), .vector_o(vector)
  );

  function automatic void model_reset();
    int rv[14] = '{0, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h1C,
                   'h80, 'h80, 'h80, 'h00, 'h00};
    for (int i = 0; i < 14; i++) m_ctrl[i] = rv[i];
    m_mask = 'h3FFE; m_sw = 'h0F; m_va = 0; m_vb = 0;
  endfunction

  function automatic void model_eval(output int lv, output int vc);
    int best = 0, win = 0;
    for (int s = 1; s <= 13; s++)
      if (irq[s] && !m_mask[s] && (m_ctrl[s] & 31) > best) begin
        best = m_ctrl[s] & 31; win = s;
      end
    if (best < 4) begin lv = 0; vc = 0; return; end
    lv = (m_ctrl[win] >> 2) & 7;
    if (m_ctrl[win] & 'h80) vc = 24 + lv;
    else if (win == 8)      vc = m_sw;
    else if (win == 12)     vc = m_va;
    else if (win == 13)     vc = m_vb;
    else                    vc = 'h0F;
  endfunction

  function automatic void model_write(int a, int d);
    if (a >= 1 && a <= 13) m_ctrl[a] = d & 'hFF;
    else if (a == 'h10)    m_mask = d & 'h3FFE;
    else if (a == 'h12)    m_sw = d & 'hFF;
    else if (a == 'h13)    m_va = d & 'hFF;
    else if (a == 'h14)    m_vb = d & 'hFF;
  endfunction

  function automatic int model_read(int a);
    if (a >= 1 && a <= 13) return m_ctrl[a];
    case (a)
      'h10: return m_mask;
      'h11: return int'(irq) & 'h3FFE;
      'h12: return m_sw;
      'h13: return m_va;
      'h14: return m_vb;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset(); exp_lvl = 0; exp_vec = 0;
    end else begin
      model_eval(exp_lvl, exp_vec);
      if (we) model_write(int'(addr), int'(wdata));
    end
  end

  // per-clock comparison of the outputs (R8 timing on every cycle)
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (int'(level) != exp_lvl || int'(vector) != exp_vec) begin
        n_bad++;
        $display("FAIL %s/R8 t=%0t level/vector actual %0d/0x%02h expected %0d/0x%02h",
                 cur_req, $time, level, vector, exp_lvl, exp_vec);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = 5'(a); wdata = 16'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input string req);
    int e;
    @(negedge clk); we = 1'b0; addr = 5'(a); #1;
    e = model_read(a);
    n_chk++;
    if (int'(rdata) != e) begin
      n_bad++;
      $display("FAIL %s read addr 0x%02h actual 0x%04h expected 0x%04h", req, a, rdata, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 10);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired in phase %s", cur_req);
    finish_up();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int a = 1; a <= 13; a++) rd_chk(a, "R1");
    rd_chk('h10, "R1"); rd_chk('h12, "R1"); rd_chk('h13, "R1"); rd_chk('h14, "R1");
    cur_req = "R10";
    rd_chk('h1F, "R10"); rd_chk(0, "R10");
    wr('h1F, 'hFFFF); rd_chk('h1F, "R10");
    // all requesting but all masked
    cur_req = "R2";
    irq = 16'hFFFF; idle(4);
    cur_req = "R9";
    wr('h10, 'hFFFF); rd_chk('h10, "R9");
    wr('h10, 0); rd_chk('h10, "R9");
    // src7 and src8 tie at key 0x1C -> src7, fallback vector
    cur_req = "R3"; idle(3);
    cur_req = "R6";
    wr('h10, 1 << 7); idle(2);           // src8 -> software vector
    wr('h12, 'h40); idle(2);
    cur_req = "R5";
    wr(9, 'h9D); idle(2);                // key 29 autovector level 7
    cur_req = "R6";
    wr('h13, 'h55); wr('h14, 'h66);
    wr(12, 'h1F); idle(2);               // src12 key 31
    cur_req = "R3";
    wr(13, 'h1F); idle(2);               // tie, src12 wins
    cur_req = "R6";
    wr('h10, 1 << 12); idle(2);          // src13
    cur_req = "R2";
    irq = 16'h0000; idle(2);
    irq = 16'h0002; wr('h10, 'hFFFC); idle(2); // only src1, fallback
    cur_req = "R4";
    wr(1, 'h83); idle(2);
    cur_req = "R5";
    wr(1, 'h87); idle(2);
    cur_req = "R9";
    wr('h10, 0); irq = 16'hC001; idle(3);
    rd_chk('h11, "R9");
    cur_req = "R7";
    irq = 16'h2A54; rd_chk('h11, "R7");
    irq = 16'h1003; rd_chk('h11, "R7");
    cur_req = "R8";
    irq = 16'h0000; idle(1); irq = 16'h2000; idle(1); irq = 16'h0000; idle(2);
    // random phase against the model
    cur_req = "R3";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk);
      irq = r[15:0];
      if (r[20:18] == 3'd0) begin
        logic [31:0] d;
        d = $urandom;
        we = 1'b1; addr = r[28:24]; wdata = d[15:0];
      end else begin
        we = 1'b0;
      end
    end
    @(negedge clk); we = 1'b0;
    idle(3);
    finish_up();
  end

endmodule